// File: doc/BRIEF.md
# DDR read capture and resynchronizer

This block takes the read half of a double-data-rate memory data path and brings it into the system clock domain. A strobe that has already been delayed by about a fifth of a period clocks a capture stage. The falling strobe edge takes the first beat of each beat pair. The following rising edge takes the second beat. A transparent latch holds the first beat so that both halves stay stable together for half a period. During that half period a resynchronization register samples them as one word, two DQ lanes wide.

The resync register can run on either edge of the resync clock. This covers the half-cycle shift that a CAS latency of 2.5 causes. By default one further register moves the word onto the rising edge of the system clock. The word stream at the output runs all the time. A separate sequencer, started by a one-cycle read request, marks the cycles that hold real read data. It places the window using the CAS latency, a programmable resync cycle offset (the round trip in whole system cycles) and the burst length. All three settings are captured when the request is accepted.

Top module: `ddr_read_capture`

## Requirements
- R1: A falling edge of `dqs_shifted` captures the first beat of a pair from `dq`, and the next rising edge captures the second beat. In `rd_data`, the first beat is the upper DQ_W bits and the second beat is the lower DQ_W bits.
- R2: When `cfg_resync_fall` is 0 the resync register samples both halves on the rising edge of `resync_clk`, and when it is 1 on the falling edge. A word whose two halves are stable only across a falling edge is captured intact when the falling phase is selected.
- R3: With the default separate resync clock, a captured word appears on `rd_data` at the next rising `sys_clk` edge after the resync capture.
- R4: `cfg_cas` codes: 0 is CL 2, 1 is CL 2.5, 2 is CL 3, 3 is also CL 3. Let W be 2 for codes 0 and 1 and 3 for codes 2 and 3. Take the `sys_clk` edge that samples `rd_req` high as edge 0. With the default build, `rd_valid` rises after edge W + 2 + `cfg_resync_cycle`.
- R5: `cfg_burst` codes: 0 is a burst of 2, 1 is 4, 2 is 8, 3 is also 8. `rd_valid` stays high for exactly burst/2 consecutive system cycles.
- R6: Each step of the 2-bit `cfg_resync_cycle` (0 to 3) delays the valid window by one system cycle. Resync cycle 0 is the first rising system edge after the first strobe falling edge.
- R7: During the k-th valid cycle, counting from 0, `rd_data` holds beat pair k of the burst, in arrival order.
- R8: A `rd_req` that arrives while a window is pending or active is ignored and produces no further window.
- R9: Driving `rst_n` low clears `rd_valid` at once and drops any pending window.
- R10: The CAS, burst and resync-cycle settings are sampled with the accepted request. Changing them later does not move or resize that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; the valid sequencer and output stage use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| resync_clk | input | 1 | Clock for the resync registers |
| dqs_shifted | input | 1 | Delayed read strobe that clocks the capture stage |
| dq | input | DQ_W | Read data lanes from the memory |
| rd_req | input | 1 | One-cycle pulse; the memory latched a read command at this edge |
| cfg_cas | input | 2 | CAS latency code |
| cfg_burst | input | 2 | Burst length code |
| cfg_resync_cycle | input | CYC_W | Whole-cycle round-trip offset |
| cfg_resync_fall | input | 1 | Resync on the falling edge of resync_clk |
| rd_data | output | 2*DQ_W | Resynchronized beat pair, first beat in the upper half |
| rd_valid | output | 1 | High on cycles that carry burst data |

## Verification
The bench acts as the memory. For each setting it drives the strobe and data with a round trip of 1 ns plus ten times the resync cycle offset. From that it predicts the exact edge at which each output is due. The first word reaches `rd_data` W + 2 + offset edges after the edge that samples the request. The following words come on the next burst/2 − 1 edges, and `rd_valid` drops one edge after the last word. Every sample is taken 2 ns after a rising `sys_clk` edge. This places it after the output register has settled and well before the next edge. All strobe and data transitions fall 1 to 3 ns away from any clock edge.

// File: rtl/ddr_rdcap_pkg.sv
package ddr_rdcap_pkg;

   // Whole system cycles of CAS latency; CL 2.5 rounds down, its half cycle
   // is absorbed by the falling-edge resync phase.
   function automatic logic [2:0] cas_whole_cycles(input logic [1:0] code);
      logic [2:0] r;
      case (code)
         2'd0:    r = 3'd2;
         2'd1:    r = 3'd2;
         default: r = 3'd3;
      endcase
      return r;
   endfunction

   // Beat pairs (output words) per burst.
   function automatic logic [2:0] burst_words(input logic [1:0] code);
      logic [2:0] r;
      case (code)
         2'd0:    r = 3'd1;
         2'd1:    r = 3'd2;
         default: r = 3'd4;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ddr_rdcap_capture.sv
module ddr_rdcap_capture #(
   parameter int DQ_W = 8
) (
   input  logic            dqs_shifted,
   input  logic [DQ_W-1:0] dq,
   output logic [DQ_W-1:0] beat_hi,
   output logic [DQ_W-1:0] beat_lo
);

   // One capture cell per lane: falling-edge register, hold latch, rising-edge register.
   for (genvar g = 0; g < DQ_W; g++) begin : g_lane
      logic hi_q;
      logic hi_hold;
      logic lo_q;

      always_ff @(negedge dqs_shifted) hi_q <= dq[g];

      // Transparent while the strobe is low, closed while it is high, so the
      // first beat stays put while the second beat is being presented.
      always_latch begin
         if (!dqs_shifted) hi_hold = hi_q;
      end

      always_ff @(posedge dqs_shifted) lo_q <= dq[g];

      assign beat_hi[g] = hi_hold;
      assign beat_lo[g] = lo_q;
   end

endmodule

// File: rtl/ddr_rdcap_resync.sv
module ddr_rdcap_resync #(
   parameter int W        = 16,
   parameter bit SEPARATE = 1'b1
) (
   input  logic         resync_clk,
   input  logic         sys_clk,
   input  logic         use_fall,
   input  logic [W-1:0] word_in,
   output logic [W-1:0] word_out
);

   logic [W-1:0] rise_q;
   logic [W-1:0] fall_q;

   always_ff @(posedge resync_clk) rise_q <= word_in;
   always_ff @(negedge resync_clk) fall_q <= word_in;

   if (SEPARATE) begin : g_sep
      // Resync clock is its own domain: one more stage onto the system edge.
      logic [W-1:0] sys_q;
      always_ff @(posedge sys_clk) sys_q <= use_fall ? fall_q : rise_q;
      assign word_out = sys_q;
   end else begin : g_shared
      // Resync clock is the system clock: only the falling phase needs retiming.
      logic [W-1:0] fall_rt;
      always_ff @(posedge sys_clk) fall_rt <= fall_q;
      assign word_out = use_fall ? fall_rt : rise_q;
   end

endmodule

// File: rtl/ddr_rdcap_window.sv
module ddr_rdcap_window
   import ddr_rdcap_pkg::*;
#(
   parameter int CYC_W = 2,
   parameter int CNT_W = 4,
   parameter int BW_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic [1:0]       cas_code,
   input  logic [1:0]       burst_code,
   input  logic [CYC_W-1:0] cyc,
   input  logic             extra,
   output logic             valid
);

   logic             pend_q;
   logic             valid_q;
   logic [CNT_W-1:0] wait_q;
   logic [BW_W-1:0]  words_q;
   logic [BW_W-1:0]  left_q;
   logic [CNT_W-1:0] lat;
   logic             busy;

   always_comb begin
      lat = CNT_W'(cas_whole_cycles(cas_code)) + CNT_W'(cyc)
          + CNT_W'(extra) + CNT_W'(1);
   end

   assign busy = pend_q | valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         wait_q  <= '0;
         words_q <= '0;
         left_q  <= '0;
      end else if (rd_req && !busy) begin
         pend_q  <= 1'b1;
         wait_q  <= lat - CNT_W'(1);
         words_q <= BW_W'(burst_words(burst_code));
      end else if (pend_q) begin
         if (wait_q == '0) begin
            pend_q  <= 1'b0;
            valid_q <= 1'b1;
            left_q  <= words_q - BW_W'(1);
         end else begin
            wait_q <= wait_q - CNT_W'(1);
         end
      end else if (valid_q) begin
         if (left_q == '0) valid_q <= 1'b0;
         else              left_q  <= left_q - BW_W'(1);
      end
   end

   assign valid = valid_q;

   // Independent run-length counter used by the window-length check.
   logic [BW_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (valid_q) run_q <= run_q + BW_W'(1);
      else              run_q <= '0;
   end

   // R5
   run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid_q) |-> (run_q == words_q));

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && rd_req) |=> !pend_q);

   // R4
   rise_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(pend_q));

   // R6
   pend_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_q && valid_q));

endmodule

// File: rtl/ddr_read_capture.sv
module ddr_read_capture #(
   parameter int DQ_W                = 8,
   parameter int CYC_W               = 2,
   parameter bit SEPARATE_RESYNC_CLK = 1'b1
) (
   input  logic              sys_clk,
   input  logic              rst_n,
   input  logic              resync_clk,
   input  logic              dqs_shifted,
   input  logic [DQ_W-1:0]   dq,
   input  logic              rd_req,
   input  logic [1:0]        cfg_cas,
   input  logic [1:0]        cfg_burst,
   input  logic [CYC_W-1:0]  cfg_resync_cycle,
   input  logic              cfg_resync_fall,
   output logic [2*DQ_W-1:0] rd_data,
   output logic              rd_valid
);

   localparam int WORD_W  = 2 * DQ_W;
   localparam int LAT_MAX = 3 + 1 + 1 + ((1 << CYC_W) - 1);
   localparam int CNT_W   = $clog2(LAT_MAX + 1);
   localparam int BW_W    = 3;

   if (DQ_W < 1 || CYC_W < 1 || CYC_W > 4) begin : g_bad_params
      $error("ddr_read_capture: DQ_W must be >= 1 and CYC_W within 1..4");
   end

   logic [DQ_W-1:0]   beat_hi;
   logic [DQ_W-1:0]   beat_lo;
   logic [WORD_W-1:0] word_cap;
   logic              lat_extra;

   ddr_rdcap_capture #(.DQ_W(DQ_W)) i_capture (
      .dqs_shifted (dqs_shifted),
      .dq          (dq),
      .beat_hi     (beat_hi),
      .beat_lo     (beat_lo)
   );

   assign word_cap = {beat_hi, beat_lo};

   ddr_rdcap_resync #(.W(WORD_W), .SEPARATE(SEPARATE_RESYNC_CLK)) i_resync (
      .resync_clk (resync_clk),
      .sys_clk    (sys_clk),
      .use_fall   (cfg_resync_fall),
      .word_in    (word_cap),
      .word_out   (rd_data)
   );

   assign lat_extra = SEPARATE_RESYNC_CLK | cfg_resync_fall;

   ddr_rdcap_window #(.CYC_W(CYC_W), .CNT_W(CNT_W), .BW_W(BW_W)) i_window (
      .clk        (sys_clk),
      .rst_n      (rst_n),
      .rd_req     (rd_req),
      .cas_code   (cfg_cas),
      .burst_code (cfg_burst),
      .cyc        (cfg_resync_cycle),
      .extra      (lat_extra),
      .valid      (rd_valid)
   );

endmodule

// File: tb/test_ddr_read_capture.sv
`timescale 1ns/1ps
module test_ddr_read_capture;

   logic        sys_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dqs_shifted = 1'b1;
   logic [7:0]  dq = '0;
   logic        rd_req = 1'b0;
   logic [1:0]  cfg_cas = '0;
   logic [1:0]  cfg_burst = '0;
   logic [1:0]  cfg_resync_cycle = '0;
   logic        cfg_resync_fall = 1'b0;
   logic [15:0] rd_data;
   logic        rd_valid;

   int n_vec = 0;
   int n_bad = 0;

   always #5 sys_clk = ~sys_clk;

   ddr_read_capture i_ddr_read_capture (
      .sys_clk          (sys_clk),
      .rst_n            (rst_n),
      .resync_clk       (sys_clk),
      .dqs_shifted      (dqs_shifted),
      .dq               (dq),
      .rd_req           (rd_req),
      .cfg_cas          (cfg_cas),
      .cfg_burst        (cfg_burst),
      .cfg_resync_cycle (cfg_resync_cycle),
      .cfg_resync_fall  (cfg_resync_fall),
      .rd_data          (rd_data),
      .rd_valid         (rd_valid)
   );

   // {cas code, burst code, resync cycle}
   localparam logic [5:0] VEC [0:7] = '{
      {2'd0, 2'd0, 2'd0}, {2'd0, 2'd1, 2'd1}, {2'd0, 2'd2, 2'd0}, {2'd1, 2'd1, 2'd0},
      {2'd1, 2'd2, 2'd2}, {2'd2, 2'd0, 2'd0}, {2'd2, 2'd2, 2'd3}, {2'd3, 2'd3, 2'd1}
   };

   task automatic chk(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int whole_cyc(input logic [1:0] c);
      return (c[1]) ? 3 : 2;
   endfunction

   function automatic int words_of(input logic [1:0] b);
      return (b == 2'd0) ? 1 : (b == 2'd1) ? 2 : 4;
   endfunction

   // Memory model: data edge-aligned, strobe already shifted by 2 ns (T/5).
   task automatic mem_drive(input int start, input int n, input logic [7:0] seed);
      #(start);
      for (int k = 0; k < n; k++) begin
         dq = seed + 8'(2 * k);
         #2 dqs_shifted = 1'b0;
         #3 dq = seed + 8'(2 * k + 1);
         #2 dqs_shifted = 1'b1;
         #3;
      end
      dq = '0;
   endtask

   task automatic do_read(input logic [1:0] cas, input logic [1:0] bst,
                          input logic [1:0] cyc, input logic [7:0] seed,
                          input bit disturb);
      int lat;
      int nw;
      int half;
      @(negedge sys_clk);
      cfg_cas          = cas;
      cfg_burst        = bst;
      cfg_resync_cycle = cyc;
      cfg_resync_fall  = (cas == 2'd1);
      rd_req           = 1'b1;
      lat  = whole_cyc(cas) + 2 + int'(cyc);
      nw   = words_of(bst);
      half = (cas == 2'd0) ? 4 : (cas == 2'd1) ? 5 : 6;
      fork
         begin
            #5;
            mem_drive(half * 5 + 1 + 10 * int'(cyc), nw, seed);
         end
         begin
            #10 rd_req = 1'b0;
         end
         begin
            if (disturb) begin
               #30;
               cfg_burst = 2'd0; cfg_resync_cycle = 2'd3; cfg_cas = 2'd0;
               rd_req = 1'b1;
               #10 rd_req = 1'b0;
            end
         end
         begin
            #7;
            for (int m = 1; m < lat + nw + 2 + (disturb ? 12 : 0); m++) begin
               bit exp_v;
               #10;
               exp_v = (m >= lat) && (m < lat + nw);
               // R4 R5 R6 R8 R10: window position and length
               chk(rd_valid == exp_v, disturb ? "R8/R10 window" : "R4/R5/R6 window",
                   16'(rd_valid), 16'(exp_v));
               if (exp_v) begin
                  logic [15:0] ew;
                  ew = {seed + 8'(2 * (m - lat)), seed + 8'(2 * (m - lat) + 1)};
                  // R1 R2 R3 R7: beat order and word content
                  chk(rd_data == ew, "R1/R2/R3/R7 data", rd_data, ew);
               end
            end
         end
      join
      repeat (3) @(negedge sys_clk);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #200000;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge sys_clk);
      // R9: valid low while in reset
      chk(rd_valid == 1'b0, "R9 reset", 16'(rd_valid), 16'd0);
      rst_n = 1'b1;
      @(negedge sys_clk);

      for (int v = 0; v < 8; v++) begin
         do_read(VEC[v][5:4], VEC[v][3:2], VEC[v][1:0], 8'(16 * v + 3), 1'b0);
      end

      // R8 and R10: second request and config change during a BL8 window
      do_read(2'd2, 2'd2, 2'd0, 8'hA0, 1'b1);

      // R9: reset while a window is pending drops it
      @(negedge sys_clk);
      cfg_cas = 2'd2; cfg_burst = 2'd2; cfg_resync_cycle = 2'd3; cfg_resync_fall = 1'b0;
      rd_req = 1'b1;
      @(negedge sys_clk);
      rd_req = 1'b0;
      repeat (2) @(negedge sys_clk);
      rst_n = 1'b0;
      #2;
      chk(rd_valid == 1'b0, "R9 reset mid-window", 16'(rd_valid), 16'd0);
      @(negedge sys_clk);
      rst_n = 1'b1;
      for (int m = 0; m < 15; m++) begin
         @(negedge sys_clk);
         chk(rd_valid == 1'b0, "R9 pending dropped", 16'(rd_valid), 16'd0);
      end

      // R4: back to normal operation after reset
      do_read(2'd0, 2'd1, 2'd0, 8'h55, 1'b0);

      finish_run();
   end

endmodule